// File: doc/BRIEF.md
# PCM Receive Frame Timebase

This block produces the frame timing for the receive side of a serial PCM output that is assembled from several subscriber-line receive channels. Each channel supplies a one-cycle pulse that marks the start of its 6 ms line frame. A configuration field names one channel as the timing master. The master's pulse is held back by a programmed number of receive clock cycles, which stands for the fill level of the receive FIFO. The delayed pulse becomes the PCM 6 ms sync.

On each PCM sync the bit, frame and multiframe counters are forced to a known position. From there they run freely. The bit position within a frame, the frame position within a multiframe and a multiframe index are output every cycle. Two strobes are also output: one marks the start of each frame and one marks the start of each multiframe. Downstream formatters use these values to place bit 0 of frame 0 on the serial line. A configuration bit selects which edge of the receive clock drives all state.

Top module: `pcm_rx_timebase`

## Requirements
- R1: The timing master is one of `NUM_CH` one-cycle sync inputs, chosen by `cfg_master`. A pulse on a channel that is neither the active master nor the newly selected one has no effect on the counters. A `cfg_master` value of `NUM_CH` or more never becomes the active master.
- R2: A change of `cfg_master` takes effect at the next pulse of the newly selected channel. Until that pulse arrives, the pulses of the previously active channel keep realigning the counters. After reset the active master is channel 0.
- R3: Let `cfg_delay` = D. When a master pulse is sampled at an active edge, the counters show the load position from the (D+2)th active edge after it. With D = 0 this is the second edge.
- R4: A master pulse that arrives while a delay is still counting restarts the delay from the new pulse. The earlier pulse then produces no realignment.
- R5: On a PCM sync, `bit_idx` loads `cfg_bit_ofs`, `frm_idx` loads `cfg_frm_ofs` and `mf_idx` loads 0.
- R6: Outside a load, `bit_idx` counts up and wraps to 0 after `cfg_frame_len`-1. The wrap advances `frm_idx`. `frm_idx` wraps to 0 after `cfg_mf_len`-1, and that wrap advances `mf_idx`. `mf_idx` wraps modulo 2^`MF_W`.
- R7: `frame_start` is 1 exactly in the cycles where `bit_idx` is 0. `mf_start` is 1 exactly where both `bit_idx` and `frm_idx` are 0.
- R8: A sampled `rx_rst` clears all three counters and discards any pending delay or master pulse, while keeping the active master. A sampled `rst` also returns the active master to channel 0.
- R9: With `clk_inv` = 0 all state changes on the rising edge of `clk_rx`. With `clk_inv` = 1 all state changes on the falling edge, and the outputs stay stable across the rising edge.
- R10: During and directly after reset, all indices are 0 and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock |
| clk_inv | input | 1 | 0: rising edge active, 1: falling edge active |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| rx_rst | input | 1 | Synchronous active-high receive reset of counters and delay |
| ch_sync | input | NUM_CH | One-cycle 6 ms frame pulses, one per channel |
| cfg_master | input | SEL_W | Requested master channel |
| cfg_delay | input | DLY_W | Cycles from master pulse to PCM sync |
| cfg_frame_len | input | BIT_W | Bits per frame (at least 1) |
| cfg_mf_len | input | FRM_W | Frames per multiframe (at least 1) |
| cfg_bit_ofs | input | BIT_W | Bit position loaded on PCM sync |
| cfg_frm_ofs | input | FRM_W | Frame position loaded on PCM sync |
| bit_idx | output | BIT_W | Bit position in frame |
| frm_idx | output | FRM_W | Frame position in multiframe |
| mf_idx | output | MF_W | Multiframe index since last sync |
| frame_start | output | 1 | High while `bit_idx` is 0 |
| mf_start | output | 1 | High while bit and frame positions are 0 |

## Verification
The assertions assume the following about the inputs:
- Each channel sync is a single-cycle pulse in the receive clock domain.
- `clk_inv` changes only while reset is held.
- The lengths and offsets satisfy offset < length, and they change only while `rx_rst` is held, so a counter never starts out beyond its wrap point.

The bench follows these rules. It loads every configuration through a task that holds `rx_rst` around the change, and it switches the clock edge only inside `rst`. It also spaces restarting pulses so that a new pulse never meets the final cycle of an earlier delay, because there the priority between an emitted sync and a reload is not something the requirements fix.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic {
    DLY_IDLE  = 1'b0,
    DLY_COUNT = 1'b1
  } dly_state_e;

  localparam int DEF_NUM_CH = 3;
  localparam int DEF_BIT_W  = 8;
  localparam int DEF_FRM_W  = 6;
  localparam int DEF_MF_W   = 4;
  localparam int DEF_DLY_W  = 10;

endpackage

// File: rtl/pcm_rx_edge_sel.sv
module pcm_rx_edge_sel (
  input  logic clk_rx,
  input  logic clk_inv,
  output logic clk_tb
);
  // Inverting the receive clock makes its falling edge the active one.
  assign clk_tb = clk_rx ^ clk_inv;
endmodule

// File: rtl/pcm_rx_master_sel.sv
module pcm_rx_master_sel #(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_rst,
  input  logic [NUM_CH-1:0] ch_sync,
  input  logic [SEL_W-1:0]  cfg_master,
  output logic              mst_pulse
);
  logic [NUM_CH-1:0] req_hit;
  logic [NUM_CH-1:0] act_hit;
  logic [SEL_W-1:0]  act_sel;

  // Per channel: does this pulse belong to the requested or the active master?
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign req_hit[g] = ch_sync[g] && (cfg_master == SEL_W'(g));
    assign act_hit[g] = ch_sync[g] && (act_sel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel   <= '0;
      mst_pulse <= 1'b0;
    end else begin
      if (|req_hit) act_sel <= cfg_master;
      mst_pulse <= !rx_rst && ((|req_hit) || (|act_hit));
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(|ch_sync) |=> $stable(act_sel)); // R2
  AST_SEL_VALID: assert property (@(posedge clk) disable iff (rst)
    act_sel < SEL_W'(NUM_CH)); // R1
  AST_MST_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(|ch_sync) |=> !mst_pulse); // R1
endmodule

// File: rtl/pcm_rx_sync_delay.sv
module pcm_rx_sync_delay
  import pcm_rx_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_rst,
  input  logic             mst_pulse,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             pcm_sync
);
  dly_state_e       state;
  logic [DLY_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || rx_rst) begin
      state    <= DLY_IDLE;
      remain   <= '0;
      pcm_sync <= 1'b0;
    end else begin
      pcm_sync <= 1'b0;
      if (mst_pulse) begin
        // A fresh master pulse always restarts the wait.
        remain <= cfg_delay;
        if (cfg_delay == '0) begin
          pcm_sync <= 1'b1;
          state    <= DLY_IDLE;
        end else begin
          state    <= DLY_COUNT;
        end
      end else if (state == DLY_COUNT) begin
        remain <= remain - 1'b1;
        if (remain == DLY_W'(1)) begin
          pcm_sync <= 1'b1;
          state    <= DLY_IDLE;
        end
      end
    end
  end

  AST_DLY_ZERO: assert property (@(posedge clk) disable iff (rst || rx_rst)
    (mst_pulse && cfg_delay == '0) |=> pcm_sync); // R3
  AST_DLY_RESTART: assert property (@(posedge clk) disable iff (rst || rx_rst)
    (mst_pulse && cfg_delay != '0) |=> (!pcm_sync && state == DLY_COUNT && remain == $past(cfg_delay))); // R4
  AST_DLY_QUIET: assert property (@(posedge clk) disable iff (rst || rx_rst)
    (!mst_pulse && state == DLY_IDLE) |=> !pcm_sync); // R3
endmodule

// File: rtl/pcm_rx_counters.sv
module pcm_rx_counters #(
  parameter int BIT_W = 8,
  parameter int FRM_W = 6,
  parameter int MF_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_rst,
  input  logic             pcm_sync,
  input  logic [BIT_W-1:0] cfg_frame_len,
  input  logic [FRM_W-1:0] cfg_mf_len,
  input  logic [BIT_W-1:0] cfg_bit_ofs,
  input  logic [FRM_W-1:0] cfg_frm_ofs,
  output logic [BIT_W-1:0] bit_idx,
  output logic [FRM_W-1:0] frm_idx,
  output logic [MF_W-1:0]  mf_idx,
  output logic             frame_start,
  output logic             mf_start
);
  logic [BIT_W-1:0] bit_last;
  logic [FRM_W-1:0] frm_last;
  logic             bit_wrap, frm_wrap;
  logic [BIT_W-1:0] bit_nx;
  logic [FRM_W-1:0] frm_nx;
  logic [MF_W-1:0]  mf_nx;

  always_comb begin
    bit_last = cfg_frame_len - 1'b1;
    frm_last = cfg_mf_len - 1'b1;
    bit_wrap = (bit_idx >= bit_last);
    frm_wrap = (frm_idx >= frm_last);
    if (pcm_sync) begin
      bit_nx = cfg_bit_ofs;
      frm_nx = cfg_frm_ofs;
      mf_nx  = '0;
    end else begin
      bit_nx = bit_wrap ? '0 : bit_idx + 1'b1;
      frm_nx = frm_idx;
      mf_nx  = mf_idx;
      if (bit_wrap) begin
        frm_nx = frm_wrap ? '0 : frm_idx + 1'b1;
        if (frm_wrap) mf_nx = mf_idx + 1'b1;
      end
    end
  end

  // Strobes are registered from the next-state values so they line up with the indices.
  always_ff @(posedge clk) begin
    if (rst || rx_rst) begin
      bit_idx     <= '0;
      frm_idx     <= '0;
      mf_idx      <= '0;
      frame_start <= 1'b1;
      mf_start    <= 1'b1;
    end else begin
      bit_idx     <= bit_nx;
      frm_idx     <= frm_nx;
      mf_idx      <= mf_nx;
      frame_start <= (bit_nx == '0);
      mf_start    <= (bit_nx == '0) && (frm_nx == '0);
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst || rx_rst)
    bit_idx < cfg_frame_len); // R6
  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (rst || rx_rst)
    (!pcm_sync && bit_idx == bit_last) |=> bit_idx == '0); // R6
  AST_FS_MATCH: assert property (@(posedge clk) disable iff (rst)
    frame_start == (bit_idx == '0)); // R7
  AST_MFS_MATCH: assert property (@(posedge clk) disable iff (rst)
    mf_start == (bit_idx == '0 && frm_idx == '0)); // R7
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (rst || rx_rst)
    pcm_sync |=> (bit_idx == $past(cfg_bit_ofs) && frm_idx == $past(cfg_frm_ofs) && mf_idx == '0)); // R5
  AST_RXRST_CLR: assert property (@(posedge clk) disable iff (rst)
    rx_rst |=> (bit_idx == '0 && frm_idx == '0 && mf_idx == '0)); // R8
endmodule

// File: rtl/pcm_rx_timebase.sv
module pcm_rx_timebase
  import pcm_rx_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int BIT_W  = DEF_BIT_W,
  parameter int FRM_W  = DEF_FRM_W,
  parameter int MF_W   = DEF_MF_W,
  parameter int DLY_W  = DEF_DLY_W,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_rx,
  input  logic              clk_inv,
  input  logic              rst,
  input  logic              rx_rst,
  input  logic [NUM_CH-1:0] ch_sync,
  input  logic [SEL_W-1:0]  cfg_master,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [BIT_W-1:0]  cfg_frame_len,
  input  logic [FRM_W-1:0]  cfg_mf_len,
  input  logic [BIT_W-1:0]  cfg_bit_ofs,
  input  logic [FRM_W-1:0]  cfg_frm_ofs,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [FRM_W-1:0]  frm_idx,
  output logic [MF_W-1:0]   mf_idx,
  output logic              frame_start,
  output logic              mf_start
);
  logic clk_tb;
  logic mst_pulse;
  logic pcm_sync;

  pcm_rx_edge_sel u_edge (
    .clk_rx  (clk_rx),
    .clk_inv (clk_inv),
    .clk_tb  (clk_tb)
  );

  pcm_rx_master_sel #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_sel (
    .clk        (clk_tb),
    .rst        (rst),
    .rx_rst     (rx_rst),
    .ch_sync    (ch_sync),
    .cfg_master (cfg_master),
    .mst_pulse  (mst_pulse)
  );

  pcm_rx_sync_delay #(.DLY_W(DLY_W)) u_dly (
    .clk       (clk_tb),
    .rst       (rst),
    .rx_rst    (rx_rst),
    .mst_pulse (mst_pulse),
    .cfg_delay (cfg_delay),
    .pcm_sync  (pcm_sync)
  );

  pcm_rx_counters #(.BIT_W(BIT_W), .FRM_W(FRM_W), .MF_W(MF_W)) u_cnt (
    .clk           (clk_tb),
    .rst           (rst),
    .rx_rst        (rx_rst),
    .pcm_sync      (pcm_sync),
    .cfg_frame_len (cfg_frame_len),
    .cfg_mf_len    (cfg_mf_len),
    .cfg_bit_ofs   (cfg_bit_ofs),
    .cfg_frm_ofs   (cfg_frm_ofs),
    .bit_idx       (bit_idx),
    .frm_idx       (frm_idx),
    .mf_idx        (mf_idx),
    .frame_start   (frame_start),
    .mf_start      (mf_start)
  );

  AST_RST_STATE: assert property (@(posedge clk_tb)
    rst |=> (bit_idx == '0 && frm_idx == '0 && mf_idx == '0 && frame_start && mf_start)); // R10
endmodule

// File: tb/pcm_rx_timebase_tb.sv
`timescale 1ns/1ps
module pcm_rx_timebase_tb;
  localparam int NCH = 3;
  localparam int BW  = 8;
  localparam int FW  = 6;
  localparam int MW  = 4;
  localparam int DW  = 10;

  logic          clk_rx = 1'b0;
  logic          clk_inv = 1'b0;
  logic          rst = 1'b1;
  logic          rx_rst = 1'b0;
  logic [NCH-1:0] ch_sync = '0;
  logic [1:0]    cfg_master = '0;
  logic [DW-1:0] cfg_delay = '0;
  logic [BW-1:0] cfg_frame_len = 8'd8;
  logic [FW-1:0] cfg_mf_len = 6'd4;
  logic [BW-1:0] cfg_bit_ofs = '0;
  logic [FW-1:0] cfg_frm_ofs = '0;
  logic [BW-1:0] bit_idx;
  logic [FW-1:0] frm_idx;
  logic [MW-1:0] mf_idx;
  logic          frame_start, mf_start;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int load_at = -1;
  int e_b = 0, e_f = 0, e_m = 0;
  int m_act = 0;

  always #10 clk_rx = ~clk_rx;

  pcm_rx_timebase u_dut (
    .clk_rx(clk_rx), .clk_inv(clk_inv), .rst(rst), .rx_rst(rx_rst),
    .ch_sync(ch_sync), .cfg_master(cfg_master), .cfg_delay(cfg_delay),
    .cfg_frame_len(cfg_frame_len), .cfg_mf_len(cfg_mf_len),
    .cfg_bit_ofs(cfg_bit_ofs), .cfg_frm_ofs(cfg_frm_ofs),
    .bit_idx(bit_idx), .frm_idx(frm_idx), .mf_idx(mf_idx),
    .frame_start(frame_start), .mf_start(mf_start)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #4000000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  // Expected-position model built from the requirements; advanced once per active edge.
  task automatic tick();
    bit counted, req_ok;
    if (clk_inv) @(negedge clk_rx); else @(posedge clk_rx);
    cyc++;
    if (rst) begin
      e_b = 0; e_f = 0; e_m = 0; m_act = 0; load_at = -1;
    end else begin
      req_ok  = (int'(cfg_master) < NCH) && ch_sync[cfg_master];
      counted = ch_sync[m_act] || req_ok;
      if (req_ok) m_act = int'(cfg_master);
      if (rx_rst) begin
        e_b = 0; e_f = 0; e_m = 0; load_at = -1;
      end else begin
        if (cyc == load_at) begin
          e_b = int'(cfg_bit_ofs); e_f = int'(cfg_frm_ofs); e_m = 0;
        end else if (e_b >= int'(cfg_frame_len) - 1) begin
          e_b = 0;
          if (e_f >= int'(cfg_mf_len) - 1) begin
            e_f = 0;
            e_m = (e_m + 1) % (1 << MW);
          end else e_f++;
        end else e_b++;
        if (counted) load_at = cyc + int'(cfg_delay) + 2;
      end
    end
    #5;
  endtask

  task automatic check(input string tag);
    bit efs, emfs;
    efs  = (e_b == 0);
    emfs = (e_b == 0) && (e_f == 0);
    checks++;
    if (int'(bit_idx) != e_b || int'(frm_idx) != e_f || int'(mf_idx) != e_m ||
        frame_start != efs || mf_start != emfs) begin
      failures++;
      $display("FAIL %s cyc=%0d: actual b=%0d f=%0d m=%0d fs=%0b mfs=%0b expected b=%0d f=%0d m=%0d fs=%0b mfs=%0b",
               tag, cyc, bit_idx, frm_idx, mf_idx, frame_start, mf_start, e_b, e_f, e_m, efs, emfs);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      check(tag);
    end
  endtask

  task automatic pulse(input int ch, input string tag);
    ch_sync[ch] = 1'b1;
    tick();
    check(tag);
    ch_sync = '0;
  endtask

  task automatic set_cfg(input int fl, input int ml, input int dly, input int bo, input int fo);
    rx_rst = 1'b1;
    tick();
    cfg_frame_len = BW'(fl);
    cfg_mf_len    = FW'(ml);
    cfg_delay     = DW'(dly);
    cfg_bit_ofs   = BW'(bo);
    cfg_frm_ofs   = FW'(fo);
    tick();
    check("R8");
    rx_rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    check("R10");
    rst = 1'b0;
    tick();
    check("R10");
  endtask

  task automatic t_freerun();
    set_cfg(8, 4, 5, 0, 0);
    run(70, "R6 R7");
  endtask

  task automatic t_align();
    cfg_master = 2'd0;
    run(3, "R6");
    pulse(0, "R1");
    run(20, "R3 R5");
  endtask

  task automatic t_offset();
    set_cfg(8, 4, 3, 3, 2);
    run(5, "R6");
    pulse(0, "R5");
    run(15, "R5");
  endtask

  task automatic t_zero_delay();
    set_cfg(6, 3, 0, 0, 0);
    run(4, "R6");
    pulse(0, "R3");
    run(10, "R3");
  endtask

  task automatic t_restart();
    set_cfg(8, 4, 8, 1, 0);
    run(2, "R6");
    pulse(0, "R4");
    run(3, "R4");
    pulse(0, "R4");
    run(20, "R4");
  endtask

  task automatic t_select();
    set_cfg(8, 4, 4, 0, 0);
    cfg_master = 2'd1;
    run(3, "R2");
    pulse(0, "R2");
    run(12, "R2");
    pulse(1, "R2");
    run(12, "R2");
    pulse(0, "R1");
    run(12, "R1");
    pulse(2, "R1");
    run(12, "R1");
    cfg_master = 2'd3;
    run(3, "R1");
    pulse(1, "R1");
    run(12, "R1");
    pulse(2, "R1");
    run(12, "R1");
    cfg_master = 2'd0;
  endtask

  task automatic t_rxrst();
    set_cfg(8, 4, 10, 2, 1);
    run(2, "R8");
    pulse(0, "R8");
    run(3, "R8");
    rx_rst = 1'b1;
    tick();
    check("R8");
    rx_rst = 1'b0;
    run(20, "R8");
  endtask

  task automatic t_mfwrap();
    set_cfg(4, 2, 0, 0, 0);
    run(140, "R6");
  endtask

  task automatic t_inverted();
    logic [BW-1:0] b_snap;
    logic [FW-1:0] f_snap;
    rst = 1'b1;
    tick();
    clk_inv = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    check("R9 R10");
    rst = 1'b0;
    set_cfg(8, 4, 2, 0, 0);
    pulse(0, "R9");
    for (int i = 0; i < 20; i++) begin
      tick();
      check("R9");
      b_snap = bit_idx;
      f_snap = frm_idx;
      #10;
      checks++;
      if (bit_idx != b_snap || frm_idx != f_snap) begin
        failures++;
        $display("FAIL R9 rising edge moved outputs: actual b=%0d f=%0d expected b=%0d f=%0d",
                 bit_idx, frm_idx, b_snap, f_snap);
      end
    end
  endtask

  initial begin
    t_reset();
    t_freerun();
    t_align();
    t_offset();
    t_zero_delay();
    t_restart();
    t_select();
    t_rxrst();
    t_mfwrap();
    t_inverted();
    summary();
    $finish;
  end
endmodule